// File: doc/BRIEF.md
# Error-Injecting SECDED FIFO

This block is a single-clock first-in first-out queue. Every stored entry is protected by a single-error-correct, double-error-detect code computed over a fixed 64-bit word. User data narrower than 64 bits is zero-padded up to the full word before encoding. The queue decodes and corrects each entry on its way out. Along with dout it reports two flags: one says that a correctable one-bit error was found, the other says that an uncorrectable two-bit error was found.

For test and bring-up, each write carries two corruption requests. The requests are stored next to the codeword and are applied to that codeword when the entry leaves the memory. Only the entry written with a request shows the error. When both requests are raised on one write, the double-bit corruption wins. The data output and both error flags have no reset. They keep whatever the last read produced, so a reset cannot wipe the evidence of an error.

Back-pressure rules: the producer raises `in_valid`, and a word is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is low exactly while the queue is full. The consumer pulls with `out_pop`. A pop is taken on an edge where the queue is not empty. One cycle later `out_valid` pulses for one cycle, and `out_data`, `out_sbiterr` and `out_dbiterr` carry that entry. The consumer cannot stall the output: it must take each result in the cycle `out_valid` is high.

Top module: `ecc_fifo`

## Requirements
- R1: While reset is low and just after it is released, `empty` is 1, `full` is 0, `in_ready` is 1 and `out_valid` is 0.
- R2: Entries leave in the order they were accepted. `out_valid` is 1 in exactly the cycle after an accepted pop, and is 0 at all other times.
- R3: After DEPTH accepted writes with no reads, `full` is 1 and `in_ready` is 0. A write offered while full is dropped, and the stored sequence is unchanged.
- R4: A pop while empty is ignored. `out_valid` stays 0 and the next accepted write is the next entry read.
- R5: A write with only the single-bit request (`in_inj_single`=1, `in_inj_double`=0) is read back with `out_sbiterr`=1, `out_dbiterr`=0 and `out_data` equal to the written word. The entries before and after it read back clean.
- R6: A write with `in_inj_double`=1 is read back with `out_dbiterr`=1 and `out_sbiterr`=0. `out_data` is left uncorrected: the written word with bits 0 and 1 inverted.
- R7: A write with both requests high behaves exactly as R6. The two flags are never high together.
- R8: A write with neither request is read back with both flags 0 and `out_data` equal to the written word.
- R9: `out_data`, `out_sbiterr` and `out_dbiterr` keep their values across a reset pulse.
- R10: When a write and a pop are both accepted in the same cycle, the occupancy does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of pointers and occupancy |
| in_valid | input | 1 | Producer offers `in_data` |
| in_ready | output | 1 | Queue can accept a word (not full) |
| in_data | input | DATA_W | Word to store |
| in_inj_single | input | 1 | Corrupt this entry by one bit |
| in_inj_double | input | 1 | Corrupt this entry by two bits (wins over single) |
| out_pop | input | 1 | Consumer requests the oldest entry |
| out_valid | output | 1 | Read result present this cycle |
| out_data | output | DATA_W | Decoded (corrected if possible) entry, no reset |
| out_sbiterr | output | 1 | Corrected one-bit error seen, no reset |
| out_dbiterr | output | 1 | Uncorrectable two-bit error seen, no reset |
| full | output | 1 | DEPTH entries held |
| empty | output | 1 | No entry held |

## Verification
Four request patterns are applied: none, single only, double only and both together. Each pattern sits between clean neighbours. This separates the correction path from the detect-only path, shows the double request winning, and shows that the corruption stays with its own entry. The queue is also filled to capacity with an extra offered word, popped while empty, and pushed and popped in the same cycle. These cases separate correct pointer gating from pointers that overrun or underrun. Finally, a reset pulse after a double-error read shows whether the output registers wrongly take a reset value.

// File: rtl/ecc_fifo_pkg.sv
package ecc_fifo_pkg;
  localparam int WORD_W = 64;
  localparam int HAM_W  = 7;
  localparam int CHK_W  = HAM_W + 1;

  // Codeword position (1-based) of data bit j; positions that are powers of two hold check bits.
  function automatic int data_pos(input int j);
    int n;
    int pos;
    n   = 0;
    pos = 0;
    for (int p = 1; p < 128; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (n == j) pos = p;
        n++;
      end
    end
    return pos;
  endfunction

  // Data bits covered by Hamming check bit k.
  function automatic logic [WORD_W-1:0] cover_mask(input int k);
    logic [WORD_W-1:0] m;
    m = '0;
    for (int j = 0; j < WORD_W; j++) m[j] = ((data_pos(j) >> k) & 1) == 1;
    return m;
  endfunction
endpackage

// File: rtl/ecc_fifo_enc.sv
module ecc_fifo_enc
  import ecc_fifo_pkg::*;
(
  input  logic [WORD_W-1:0] data,
  output logic [CHK_W-1:0]  chk
);
  logic [HAM_W-1:0] ham;

  for (genvar k = 0; k < HAM_W; k++) begin : g_ham
    localparam logic [WORD_W-1:0] MASK = cover_mask(k);
    assign ham[k] = ^(data & MASK);
  end

  assign chk = {^{data, ham}, ham};
endmodule

// File: rtl/ecc_fifo_dec.sv
module ecc_fifo_dec
  import ecc_fifo_pkg::*;
#(
  parameter int OUT_W = 16
) (
  input  logic [WORD_W-1:0] data,
  input  logic [CHK_W-1:0]  chk,
  output logic [OUT_W-1:0]  fixed,
  output logic              sbe,
  output logic              dbe
);
  logic [HAM_W-1:0] syn;
  logic             odd;

  for (genvar k = 0; k < HAM_W; k++) begin : g_syn
    localparam logic [WORD_W-1:0] MASK = cover_mask(k);
    assign syn[k] = chk[k] ^ (^(data & MASK));
  end

  assign odd = ^{data, chk};

  // Flip a data bit only when the overall parity is odd and the syndrome points at it.
  for (genvar j = 0; j < OUT_W; j++) begin : g_fix
    localparam int POS = data_pos(j);
    assign fixed[j] = data[j] ^ (odd && (syn == HAM_W'(POS)));
  end

  assign sbe = odd;
  assign dbe = !odd && (syn != '0);
endmodule

// File: rtl/ecc_fifo_ctrl.sv
module ecc_fifo_ctrl #(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_req,
  input  logic             rd_req,
  output logic             wr_ok,
  output logic             rd_ok,
  output logic [PTR_W-1:0] wr_idx,
  output logic [PTR_W-1:0] rd_idx,
  output logic             full,
  output logic             empty
);
  logic [CNT_W-1:0] count;

  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);
  assign wr_ok = wr_req && !full;
  assign rd_ok = rd_req && !empty;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_idx <= '0;
      rd_idx <= '0;
      count  <= '0;
    end else begin
      if (wr_ok) wr_idx <= bump(wr_idx);
      if (rd_ok) rd_idx <= bump(rd_idx);
      if (wr_ok && !rd_ok)      count <= count + 1'b1;
      else if (rd_ok && !wr_ok) count <= count - 1'b1;
    end
  end

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_req && !rd_req) |=> (full && wr_idx == $past(wr_idx)));
  // R3
  full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));
  // R4
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rd_req && !wr_req) |=> (empty && rd_idx == $past(rd_idx)));
  // R10
  occupancy_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && rd_ok) |=> (count == $past(count)));
endmodule

// File: rtl/ecc_fifo_store.sv
module ecc_fifo_store #(
  parameter int DEPTH = 8,
  parameter int ENT_W = 72,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [PTR_W-1:0] wr_idx,
  input  logic [ENT_W-1:0] wr_word,
  input  logic [1:0]       wr_inj,
  input  logic [PTR_W-1:0] rd_idx,
  output logic [ENT_W-1:0] rd_word
);
  // Each slot holds the clean codeword plus its corruption requests {double, single}.
  logic [ENT_W+1:0] mem [DEPTH];
  logic [ENT_W+1:0] slot;
  logic [ENT_W-1:0] flip;

  always_ff @(posedge clk) begin
    if (we) mem[wr_idx] <= {wr_inj, wr_word};
  end

  assign slot = mem[rd_idx];

  // Double request wins: flip data bits 0 and 1; single flips data bit 0 only.
  always_comb begin
    flip = '0;
    if (slot[ENT_W+1])    flip[1:0] = 2'b11;
    else if (slot[ENT_W]) flip[0]   = 1'b1;
  end

  assign rd_word = slot[ENT_W-1:0] ^ flip;
endmodule

// File: rtl/ecc_fifo.sv
module ecc_fifo
  import ecc_fifo_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int ENT_W = WORD_W + CHK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_inj_single,
  input  logic              in_inj_double,
  input  logic              out_pop,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_sbiterr,
  output logic              out_dbiterr,
  output logic              full,
  output logic              empty
);
  logic             wr_ok, rd_ok;
  logic [PTR_W-1:0] wr_idx, rd_idx;
  logic [WORD_W-1:0] pad_word;
  logic [CHK_W-1:0]  pad_chk;
  logic [ENT_W-1:0]  rd_word;
  logic [DATA_W-1:0] dec_data;
  logic              dec_sbe, dec_dbe;

  ecc_fifo_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_req (in_valid),
    .rd_req (out_pop),
    .wr_ok  (wr_ok),
    .rd_ok  (rd_ok),
    .wr_idx (wr_idx),
    .rd_idx (rd_idx),
    .full   (full),
    .empty  (empty)
  );

  assign in_ready = !full;
  assign pad_word = WORD_W'(in_data);

  ecc_fifo_enc enc_i (
    .data (pad_word),
    .chk  (pad_chk)
  );

  ecc_fifo_store #(.DEPTH(DEPTH), .ENT_W(ENT_W)) store_i (
    .clk     (clk),
    .we      (wr_ok),
    .wr_idx  (wr_idx),
    .wr_word ({pad_chk, pad_word}),
    .wr_inj  ({in_inj_double, in_inj_single}),
    .rd_idx  (rd_idx),
    .rd_word (rd_word)
  );

  ecc_fifo_dec #(.OUT_W(DATA_W)) dec_i (
    .data  (rd_word[WORD_W-1:0]),
    .chk   (rd_word[ENT_W-1:WORD_W]),
    .fixed (dec_data),
    .sbe   (dec_sbe),
    .dbe   (dec_dbe)
  );

  // Result registers deliberately have no reset.
  always_ff @(posedge clk) begin
    if (rd_ok) begin
      out_data    <= dec_data;
      out_sbiterr <= dec_sbe;
      out_dbiterr <= dec_dbe;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= rd_ok;
  end

  // R2
  pop_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_pop && !empty) |=> out_valid);
  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_pop && !empty) |=> !out_valid);
  // R7
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_sbiterr && out_dbiterr));
  // R1
  reset_empty_chk: assert property (@(posedge clk)
    $past(!rst_n) |-> (empty && !full && in_ready));
endmodule

// File: tb/ecc_fifo_tb_top.sv
module ecc_fifo_tb_top;
  localparam int DW    = 16;
  localparam int DEPTH = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0, in_inj_single = 1'b0, in_inj_double = 1'b0, out_pop = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          in_ready, out_valid, out_sbiterr, out_dbiterr, full, empty;
  logic [DW-1:0] out_data;

  always #5 clk = ~clk;

  ecc_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_inj_single(in_inj_single), .in_inj_double(in_inj_double), .out_pop(out_pop),
    .out_valid(out_valid), .out_data(out_data), .out_sbiterr(out_sbiterr),
    .out_dbiterr(out_dbiterr), .full(full), .empty(empty)
  );

  typedef struct {
    logic [DW-1:0] data;
    logic          sb;
    logic          db;
    string         req;
  } exp_t;

  exp_t sb_q[$];
  int   checks = 0;
  int   fails = 0;
  int   model_cnt = 0;
  logic exp_valid = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Monitor: sample shortly after each edge, compare with the scoreboard.
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      check(out_valid == exp_valid, "R2", "out_valid", 32'(out_valid), 32'(exp_valid));
      if (exp_valid && out_valid) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R2", "unexpected result", 32'(out_data), 0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check(out_data == e.data, e.req, "out_data", 32'(out_data), 32'(e.data));
          check(out_sbiterr == e.sb, e.req, "out_sbiterr", 32'(out_sbiterr), 32'(e.sb));
          check(out_dbiterr == e.db, e.req, "out_dbiterr", 32'(out_dbiterr), 32'(e.db));
        end
      end
    end
  end

  // Driver: one cycle of stimulus, updating the model and scoreboard.
  task automatic step(input bit wv, input logic [DW-1:0] d, input bit si, input bit di,
                      input bit pop, input string req);
    bit wa, ra;
    @(negedge clk);
    check(in_ready == (model_cnt < DEPTH), "R3", "in_ready", 32'(in_ready), 32'(model_cnt < DEPTH));
    check(full == (model_cnt == DEPTH), "R3", "full", 32'(full), 32'(model_cnt == DEPTH));
    check(empty == (model_cnt == 0), "R4", "empty", 32'(empty), 32'(model_cnt == 0));
    in_valid = wv; in_data = d; in_inj_single = si; in_inj_double = di; out_pop = pop;
    wa = wv && (model_cnt < DEPTH);
    ra = pop && (model_cnt > 0);
    if (wa) sb_q.push_back('{data: di ? (d ^ DW'(3)) : d, sb: si && !di, db: di, req: req});
    exp_valid = ra;
    model_cnt = model_cnt + int'(wa) - int'(ra);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0, 1'b0, 1'b0, "R2");
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; out_pop = 1'b0; in_inj_single = 1'b0; in_inj_double = 1'b0;
    exp_valid = 1'b0; model_cnt = 0; sb_q.delete();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog", "timeout", 0, 1);
    finish_run();
  end

  initial begin
    logic [DW-1:0] h_data;
    logic          h_sb, h_db;
    do_reset();
    // R1 reset state
    @(negedge clk);
    check(empty == 1'b1, "R1", "empty", 32'(empty), 1);
    check(full == 1'b0, "R1", "full", 32'(full), 0);
    check(in_ready == 1'b1, "R1", "in_ready", 32'(in_ready), 1);
    check(out_valid == 1'b0, "R1", "out_valid", 32'(out_valid), 0);

    // R4: pop while empty ignored
    step(1'b0, '0, 1'b0, 1'b0, 1'b1, "R4");
    step(1'b0, '0, 1'b0, 1'b0, 1'b1, "R4");
    step(1'b1, 16'h4D2C, 1'b0, 1'b0, 1'b0, "R4");
    step(1'b0, '0, 1'b0, 1'b0, 1'b1, "R4");
    idle(2);

    // R8 and R2: clean entries in order
    step(1'b1, 16'h1234, 1'b0, 1'b0, 1'b0, "R8");
    step(1'b1, 16'hFFFF, 1'b0, 1'b0, 1'b0, "R8");
    step(1'b1, 16'h0000, 1'b0, 1'b0, 1'b0, "R8");
    step(1'b1, 16'hA5A5, 1'b0, 1'b0, 1'b0, "R2");
    for (int i = 0; i < 4; i++) step(1'b0, '0, 1'b0, 1'b0, 1'b1, "R2");
    idle(2);

    // R5, R6, R7 between clean neighbours
    step(1'b1, 16'h0F0F, 1'b0, 1'b0, 1'b0, "R5");
    step(1'b1, 16'hBEEF, 1'b1, 1'b0, 1'b0, "R5");
    step(1'b1, 16'h3C3C, 1'b0, 1'b0, 1'b0, "R5");
    step(1'b1, 16'hC0DE, 1'b0, 1'b1, 1'b0, "R6");
    step(1'b1, 16'h7001, 1'b0, 1'b0, 1'b0, "R6");
    step(1'b1, 16'h5AA5, 1'b1, 1'b1, 1'b0, "R7");
    step(1'b1, 16'h0002, 1'b0, 1'b0, 1'b0, "R7");
    for (int i = 0; i < 7; i++) step(1'b0, '0, 1'b0, 1'b0, 1'b1, "R5");
    idle(2);

    // R3: fill, offer one extra, drain
    for (int i = 0; i < DEPTH; i++) step(1'b1, DW'(16'h1100 + i), 1'b0, 1'b0, 1'b0, "R3");
    step(1'b1, 16'hDEAD, 1'b0, 1'b0, 1'b0, "R3");
    step(1'b1, 16'hDEAD, 1'b1, 1'b1, 1'b0, "R3");
    for (int i = 0; i < DEPTH; i++) step(1'b0, '0, 1'b0, 1'b0, 1'b1, "R3");
    idle(2);

    // R10: simultaneous push and pop keep occupancy
    step(1'b1, 16'h2001, 1'b0, 1'b0, 1'b0, "R10");
    step(1'b1, 16'h2002, 1'b0, 1'b0, 1'b0, "R10");
    for (int i = 0; i < 5; i++) step(1'b1, DW'(16'h3000 + i), 1'b0, 1'b0, 1'b1, "R10");
    step(1'b0, '0, 1'b0, 1'b0, 1'b1, "R10");
    step(1'b0, '0, 1'b0, 1'b0, 1'b1, "R10");
    // push+pop when empty: pop ignored
    step(1'b1, 16'h4444, 1'b0, 1'b0, 1'b1, "R10");
    step(1'b0, '0, 1'b0, 1'b0, 1'b1, "R10");
    idle(2);

    // R9: last read carries a double error, then reset
    step(1'b1, 16'h9876, 1'b0, 1'b1, 1'b0, "R9");
    step(1'b0, '0, 1'b0, 1'b0, 1'b1, "R9");
    idle(2);
    @(negedge clk);
    h_data = out_data; h_sb = out_sbiterr; h_db = out_dbiterr;
    check(h_data == 16'h9875, "R9", "pre-reset out_data", 32'(h_data), 32'h9875);
    rst_n = 1'b0; exp_valid = 1'b0; model_cnt = 0; sb_q.delete();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(out_data == h_data, "R9", "out_data held", 32'(out_data), 32'(h_data));
      check(out_sbiterr == h_sb, "R9", "out_sbiterr held", 32'(out_sbiterr), 32'(h_sb));
      check(out_dbiterr == h_db, "R9", "out_dbiterr held", 32'(out_dbiterr), 32'(h_db));
    end
    rst_n = 1'b1;
    @(negedge clk);
    check(empty == 1'b1, "R1", "empty after reset", 32'(empty), 1);
    check(out_dbiterr == 1'b1, "R9", "out_dbiterr after reset", 32'(out_dbiterr), 1);
    idle(2);
    finish_run();
  end
endmodule